// File: doc/BRIEF.md
# Paged Program Counter Unit

This unit holds the 13-bit program counter of a small 8-bit microcontroller core and chooses its next value every clock. By default the counter advances by one and wraps at the top of the 8K-word space. Decode tells it, through a small operation code, when to take an absolute jump or a subroutine call, a computed jump, or a return. An interrupt request takes priority over the operation code and sends the counter to a fixed vector.

Jump and call instructions carry only an 11-bit target. The two missing high bits come from a software-visible page latch. A computed jump is made by writing a new low byte, which is the result of the core's add. It takes all five upper bits from the same latch, so a jump table never carries into the next 256-word block on its own. Returns load all 13 bits from the value popped off the return-address stack and ignore the latch. On a call or an interrupt the unit presents the 13-bit address to push. The stack, the decoder, the adder and program memory are outside the unit.

Top module: `paged_pc_unit`

## Requirements
- R1: While `rst` is high at a rising edge, the counter becomes 0x000 and the page latch becomes zero. Both take effect at the next edge.
- R2: When `irq_take` is low and `pc_op` is 000 or 101..111, the counter becomes its current value plus one, modulo 8192, so 0x1FFF is followed by 0x000.
- R3: When `irq_take` is low and `pc_op` is 001 (jump), the counter becomes {latch[4:3], jump_field[10:0]}.
- R4: When `irq_take` is low and `pc_op` is 010 (call), the counter loads the same target as R3. In that cycle `push_valid` is 1 and `push_addr` is the current counter plus one, modulo 8192.
- R5: When `irq_take` is low and `pc_op` is 011 (computed jump), the counter becomes {latch[4:0], low_data[7:0]}.
- R6: When `irq_take` is low and `pc_op` is 100 (return), the counter becomes `ret_addr` exactly, whatever the latch holds.
- R7: When `irq_take` is high, the counter becomes 0x004 whatever `pc_op` is. In that cycle `push_valid` is 1 and `push_addr` is the current counter.
- R8: A latch write stores `latch_wr_data[4:0]`, and `latch_rd_data` reads back those bits with bits 7:5 at zero. A jump, call or computed jump in the same cycle uses the latch value from before the write.
- R9: `push_valid` is 0 whenever neither a call nor an interrupt is taken, and also while `rst` is high.
- R10: Without a latch write, the latch keeps its value through calls, returns, interrupts and every other operation.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| pc_op | input | 3 | Operation: 000 step, 001 jump, 010 call, 011 computed jump, 100 return, others step |
| irq_take | input | 1 | Take the interrupt vector this cycle (overrides pc_op) |
| jump_field | input | 11 | Target bits from a jump or call instruction |
| low_data | input | 8 | New low byte for a computed jump |
| ret_addr | input | 13 | Address popped from the return-address stack |
| latch_wr_en | input | 1 | Write strobe for the page latch |
| latch_wr_data | input | 8 | Data for the page latch |
| pc | output | 13 | Current program counter |
| push_valid | output | 1 | An address is to be pushed this cycle |
| push_addr | output | 13 | Address to push |
| latch_rd_data | output | 8 | Page latch read value, bits 7:5 zero |

## Verification
Directed sequences come first. A step across 0x1FFF separates a true 13-bit wrap from a wider or narrower counter. A jump with both page bits set shows that the page bits, rather than zeros, fill the top. A computed jump at 0xFF with a latch write in the same cycle shows whether the pre-write latch value is used. A later computed jump with the new latch value shows that all five bits are taken and no carry leaks in. An interrupt raised together with a call shows the priority and which address is pushed. A long stretch of random operations, interrupts, latch writes and occasional resets follows. A behavioural model checks it on every clock, including the unused operation codes.

// File: rtl/pcu_pkg.sv
package pcu_pkg;

    localparam int PC_W       = 13;
    localparam int FIELD_W    = 11;
    localparam int LOW_W      = 8;
    localparam int LATCH_W    = 8;
    localparam int HIGH_W     = PC_W - LOW_W;
    localparam int PAGE_BITS  = PC_W - FIELD_W;
    localparam int PAGE_LSB   = FIELD_W - LOW_W;
    localparam int LATCH_IMPL = HIGH_W;

    localparam logic [PC_W-1:0] DEF_RST_VEC = '0;
    localparam logic [PC_W-1:0] DEF_IRQ_VEC = PC_W'(4);

    typedef logic [PC_W-1:0]       pc_t;
    typedef logic [LATCH_IMPL-1:0] page_t;

    typedef enum logic [2:0] {
        OP_STEP  = 3'b000,
        OP_JUMP  = 3'b001,
        OP_CALL  = 3'b010,
        OP_LOWWR = 3'b011,
        OP_RET   = 3'b100
    } pc_op_e;

    typedef struct packed {
        pc_t  next_pc;
        logic push_en;
        pc_t  push_pc;
    } pc_plan_t;

    function automatic pc_t pc_inc(input pc_t p);
        return p + pc_t'(1);
    endfunction

    function automatic pc_t paged_target(input page_t pg,
                                         input logic [FIELD_W-1:0] fld);
        return {pg[PAGE_LSB +: PAGE_BITS], fld};
    endfunction

    function automatic pc_t table_target(input page_t pg,
                                         input logic [LOW_W-1:0] lo);
        return {pg[HIGH_W-1:0], lo};
    endfunction

endpackage

// File: rtl/pcu_page_latch.sv
module pcu_page_latch
    import pcu_pkg::*;
(
    input  logic               clk,
    input  logic               rst,
    input  logic               wr_en,
    input  logic [LATCH_W-1:0] wr_data,
    output page_t              page,
    output logic [LATCH_W-1:0] rd_data
);
    page_t page_q;

    always_ff @(posedge clk) begin
        if (rst)
            page_q <= '0;
        else if (wr_en)
            page_q <= wr_data[LATCH_IMPL-1:0];
    end

    assign page = page_q;

    // implemented bits read back, the rest read as zero
    for (genvar b = 0; b < LATCH_W; b++) begin : g_rd
        if (b < LATCH_IMPL) begin : g_impl
            assign rd_data[b] = page_q[b];
        end else begin : g_zero
            assign rd_data[b] = 1'b0;
        end
    end

endmodule

// File: rtl/pcu_next_sel.sv
module pcu_next_sel
    import pcu_pkg::*;
#(
    parameter pc_t IRQ_VEC = DEF_IRQ_VEC
) (
    input  pc_t                cur_pc,
    input  logic [2:0]         op,
    input  logic               irq,
    input  logic [FIELD_W-1:0] field,
    input  logic [LOW_W-1:0]   low,
    input  pc_t                ret,
    input  page_t              page,
    output pc_plan_t           plan
);
    pc_op_e op_e;
    pc_t    seq_pc;

    assign op_e   = pc_op_e'(op);
    assign seq_pc = pc_inc(cur_pc);

    always_comb begin
        plan.next_pc = seq_pc;
        plan.push_en = 1'b0;
        plan.push_pc = seq_pc;
        if (irq) begin
            plan.next_pc = IRQ_VEC;
            plan.push_en = 1'b1;
            plan.push_pc = cur_pc;
        end else begin
            unique case (op_e)
                OP_JUMP:  plan.next_pc = paged_target(page, field);
                OP_CALL: begin
                    plan.next_pc = paged_target(page, field);
                    plan.push_en = 1'b1;
                end
                OP_LOWWR: plan.next_pc = table_target(page, low);
                OP_RET:   plan.next_pc = ret;
                default:  plan.next_pc = seq_pc;
            endcase
        end
    end

endmodule

// File: rtl/pcu_pc_reg.sv
module pcu_pc_reg
    import pcu_pkg::*;
#(
    parameter pc_t RST_VEC = DEF_RST_VEC
) (
    input  logic clk,
    input  logic rst,
    input  pc_t  d,
    output pc_t  q
);
    always_ff @(posedge clk) begin
        if (rst)
            q <= RST_VEC;
        else
            q <= d;
    end
endmodule

// File: rtl/paged_pc_unit.sv
module paged_pc_unit
    import pcu_pkg::*;
#(
    parameter logic [PC_W-1:0] RST_VEC = DEF_RST_VEC,
    parameter logic [PC_W-1:0] IRQ_VEC = DEF_IRQ_VEC
) (
    input  logic               clk,
    input  logic               rst,
    input  logic [2:0]         pc_op,
    input  logic               irq_take,
    input  logic [FIELD_W-1:0] jump_field,
    input  logic [LOW_W-1:0]   low_data,
    input  logic [PC_W-1:0]    ret_addr,
    input  logic               latch_wr_en,
    input  logic [LATCH_W-1:0] latch_wr_data,
    output logic [PC_W-1:0]    pc,
    output logic               push_valid,
    output logic [PC_W-1:0]    push_addr,
    output logic [LATCH_W-1:0] latch_rd_data
);
    page_t    page;
    pc_t      pc_q;
    pc_plan_t plan;

    pcu_page_latch u_latch (
        .clk     (clk),
        .rst     (rst),
        .wr_en   (latch_wr_en),
        .wr_data (latch_wr_data),
        .page    (page),
        .rd_data (latch_rd_data)
    );

    pcu_next_sel #(.IRQ_VEC(IRQ_VEC)) u_sel (
        .cur_pc (pc_q),
        .op     (pc_op),
        .irq    (irq_take),
        .field  (jump_field),
        .low    (low_data),
        .ret    (ret_addr),
        .page   (page),
        .plan   (plan)
    );

    pcu_pc_reg #(.RST_VEC(RST_VEC)) u_pc (
        .clk (clk),
        .rst (rst),
        .d   (plan.next_pc),
        .q   (pc_q)
    );

    assign pc         = pc_q;
    assign push_valid = plan.push_en & ~rst;
    assign push_addr  = plan.push_pc;

endmodule

// File: rtl/pcu_checker.sv
module pcu_checker
    import pcu_pkg::*;
#(
    parameter logic [PC_W-1:0] RST_VEC = DEF_RST_VEC,
    parameter logic [PC_W-1:0] IRQ_VEC = DEF_IRQ_VEC
) (
    input logic               clk,
    input logic               rst,
    input logic [2:0]         pc_op,
    input logic               irq_take,
    input logic [FIELD_W-1:0] jump_field,
    input logic [LOW_W-1:0]   low_data,
    input logic [PC_W-1:0]    ret_addr,
    input logic               latch_wr_en,
    input logic [LATCH_W-1:0] latch_wr_data,
    input logic [PC_W-1:0]    pc,
    input logic               push_valid,
    input logic [PC_W-1:0]    push_addr,
    input logic [LATCH_W-1:0] latch_rd_data
);
    logic is_jump, is_call, is_low, is_ret, is_step;
    assign is_jump = !irq_take && pc_op == 3'b001;
    assign is_call = !irq_take && pc_op == 3'b010;
    assign is_low  = !irq_take && pc_op == 3'b011;
    assign is_ret  = !irq_take && pc_op == 3'b100;
    assign is_step = !irq_take && !is_jump && !is_call && !is_low && !is_ret;

    a_r1_reset: assert property (@(posedge clk)
        rst |=> (pc == RST_VEC && latch_rd_data == '0));

    a_r2_step: assert property (@(posedge clk) disable iff (rst)
        is_step |=> pc == PC_W'($past(pc) + 1'b1));

    a_r3_jump: assert property (@(posedge clk) disable iff (rst)
        is_jump |=> pc == {$past(latch_rd_data[PAGE_LSB +: PAGE_BITS]), $past(jump_field)});

    a_r4_call: assert property (@(posedge clk) disable iff (rst)
        is_call |=> pc == {$past(latch_rd_data[PAGE_LSB +: PAGE_BITS]), $past(jump_field)});

    a_r4_call_push: assert property (@(posedge clk) disable iff (rst)
        is_call |-> (push_valid && push_addr == PC_W'(pc + 1'b1)));

    a_r5_table: assert property (@(posedge clk) disable iff (rst)
        is_low |=> pc == {$past(latch_rd_data[HIGH_W-1:0]), $past(low_data)});

    a_r6_return: assert property (@(posedge clk) disable iff (rst)
        is_ret |=> pc == $past(ret_addr));

    a_r7_vector: assert property (@(posedge clk) disable iff (rst)
        irq_take |=> pc == IRQ_VEC);

    a_r7_push: assert property (@(posedge clk) disable iff (rst)
        irq_take |-> (push_valid && push_addr == pc));

    a_r8_latch_wr: assert property (@(posedge clk) disable iff (rst)
        latch_wr_en |=> latch_rd_data == LATCH_W'($past(latch_wr_data[LATCH_IMPL-1:0])));

    a_r9_no_push: assert property (@(posedge clk)
        (rst || (!irq_take && !is_call)) |-> !push_valid);

    a_r10_latch_hold: assert property (@(posedge clk) disable iff (rst)
        !latch_wr_en |=> $stable(latch_rd_data));

endmodule

bind paged_pc_unit pcu_checker u_chk (.*);

// File: tb/paged_pc_unit_bench.sv
module paged_pc_unit_bench;
    localparam int CLK_PERIOD = 10;
    localparam int WATCHDOG   = 20000;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [2:0]  pc_op = '0;
    logic        irq_take = 1'b0;
    logic [10:0] jump_field = '0;
    logic [7:0]  low_data = '0;
    logic [12:0] ret_addr = '0;
    logic        latch_wr_en = 1'b0;
    logic [7:0]  latch_wr_data = '0;
    logic [12:0] pc;
    logic        push_valid;
    logic [12:0] push_addr;
    logic [7:0]  latch_rd_data;

    paged_pc_unit u_paged_pc_unit (.*);

    always #(CLK_PERIOD/2) clk = ~clk;

    int    vectors = 0;
    int    miscompares = 0;
    int    m_pc = 0;
    int    m_latch = 0;
    string pc_tag = "R1";
    bit    done = 0;

    task automatic chk(input string tag, input int act, input int exp);
        vectors++;
        if (act != exp) begin
            miscompares++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic apply(input bit r, input int op, input bit irq, input int fld,
                         input int lo, input int ra, input bit lwe, input int lwd);
        int  exp_pv, exp_pa, nxt;
        @(negedge clk);
        rst = r; pc_op = op[2:0]; irq_take = irq; jump_field = fld[10:0];
        low_data = lo[7:0]; ret_addr = ra[12:0]; latch_wr_en = lwe; latch_wr_data = lwd[7:0];
        #1;
        // registered state from previous cycle
        chk(pc_tag, int'(pc), m_pc);
        chk("R8 R10 latch readback", int'(latch_rd_data), m_latch);
        // combinational push outputs
        exp_pv = 0; exp_pa = 0;
        if (!r && irq) begin exp_pv = 1; exp_pa = m_pc; end
        else if (!r && op == 2) begin exp_pv = 1; exp_pa = (m_pc + 1) % 8192; end
        chk("R4 R7 R9 push_valid", int'(push_valid), exp_pv);
        if (exp_pv == 1) chk("R4 R7 push_addr", int'(push_addr), exp_pa);
        // model next state
        if (r) begin
            nxt = 0; m_latch = 0; pc_tag = "R1 reset pc";
        end else begin
            if (irq) begin nxt = 4; pc_tag = "R7 vector"; end
            else case (op)
                1: begin nxt = ((m_latch >> 3) & 3) * 2048 + (fld & 2047); pc_tag = "R3 jump"; end
                2: begin nxt = ((m_latch >> 3) & 3) * 2048 + (fld & 2047); pc_tag = "R4 call"; end
                3: begin nxt = (m_latch & 31) * 256 + (lo & 255); pc_tag = "R5 computed jump"; end
                4: begin nxt = ra & 8191; pc_tag = "R6 return"; end
                default: begin nxt = (m_pc + 1) % 8192; pc_tag = "R2 step"; end
            endcase
            if (lwe) m_latch = lwd & 31;
        end
        m_pc = nxt;
    endtask

    initial begin
        apply(1, 0, 0, 0, 0, 0, 0, 0);
        apply(1, 2, 0, 0, 0, 0, 1, 8'hFF);   // R1 and R9: no push, no latch write in reset
        apply(0, 0, 0, 0, 0, 0, 0, 0);       // R1 reset state checked here
        apply(0, 0, 0, 0, 0, 0, 0, 0);       // R2
        apply(0, 5, 0, 0, 0, 0, 0, 0);       // R2 unused code
        apply(0, 0, 0, 0, 0, 0, 1, 8'hFA);   // R8 bits 7:5 dropped
        apply(0, 1, 0, 11'h7FF, 0, 0, 0, 0); // R3 -> 0x1FFF
        apply(0, 0, 0, 0, 0, 0, 0, 0);       // R2 wrap to 0
        apply(0, 2, 0, 11'h123, 0, 0, 0, 0); // R4 call
        apply(0, 3, 0, 0, 8'hFF, 0, 1, 8'h05); // R5 + R8 old latch used
        apply(0, 3, 0, 0, 8'h10, 0, 0, 0);   // R5 new latch
        apply(0, 4, 0, 0, 0, 13'h0ABC, 0, 0); // R6
        apply(0, 2, 1, 11'h3FF, 0, 0, 0, 0); // R7 irq beats call
        apply(0, 4, 0, 0, 0, 13'h1FFF, 0, 0); // R6 R10 latch untouched
        apply(0, 0, 0, 0, 0, 0, 0, 0);
        for (int i = 0; i < 4000; i++) begin
            apply(($urandom_range(0, 199) == 0), $urandom_range(0, 7),
                  ($urandom_range(0, 15) == 0), $urandom_range(0, 2047),
                  $urandom_range(0, 255), $urandom_range(0, 8191),
                  ($urandom_range(0, 7) == 0), $urandom_range(0, 255));
        end
        apply(0, 0, 0, 0, 0, 0, 0, 0);
        done = 1;
        $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
        $finish;
    end

    initial begin
        repeat (WATCHDOG) @(posedge clk);
        if (!done) begin
            miscompares++;
            $display("FAIL watchdog actual=%0d expected=%0d", WATCHDOG, 0);
            $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
            $finish;
        end
    end

endmodule